// File: doc/BRIEF.md
# Paired Instruction Address Comparator

This block watches the stream of instruction fetch addresses and raises debug event pulses when a fetch meets a programmed condition. It holds two compare registers, A and B, and one control word. A two-bit mode field in that word decides how the pair is used: as two separate exact matches, as a value-and-mask match, as an address window, or as everything outside a window.

Each comparator has three qualifiers: an enable bit, a privilege filter and an address-space filter. In the combined modes (mask, window, outside-window) the pair produces one event on output A. Only comparator A's qualifiers apply to that event, and output B stays low. The event outputs are combinational from the fetch inputs and the registered configuration. A fetch is always compared against the configuration that was in the registers at the start of its cycle.

Software writes the configuration through a small write port. Word 0 holds address A, word 1 holds address B and word 2 holds the control word. A write takes effect at the clock edge that ends the write cycle.

Top module: `iac_pair`

## Requirements
- R1: After reset, compare registers A and B and the control word are all zero. This means exact mode, both comparators disabled, and no privilege or space filtering, so no event is raised until software writes the control word.
- R2: Control bit 0 enables event A and bit 1 enables event B. With an enable clear, its event never asserts, whatever the mode.
- R3: Mode 0 (control bits 11:10 = 00) is exact compare. Event A asserts when the fetch address equals register A, and event B asserts when it equals register B, each independently of the other.
- R4: Mode 1 is masked match. Event A asserts when (fetch AND B) equals (A AND B).
- R5: Mode 2 is inclusive window. Event A asserts when A <= fetch < B, with an unsigned compare.
- R6: Mode 3 is outside window. Event A asserts when fetch < A or fetch >= B, with an unsigned compare.
- R7: Each comparator has a privilege filter: bits 3:2 for A and bits 7:6 for B. Code 00 lets every fetch through. Code 01 blocks all events. Code 10 allows events only when priv_user = 0. Code 11 allows events only when priv_user = 1.
- R8: Each comparator has an address-space filter: bits 5:4 for A and bits 9:8 for B. Code 00 lets every fetch through. Code 01 (real-address compare) never matches. Code 10 allows events only when addr_space = 0. Code 11 allows events only when addr_space = 1.
- R9: In modes 1, 2 and 3, event B never asserts. The combined event A uses only comparator A's enable, privilege filter and space filter.
- R10: An event asserts only in a cycle where fetch_valid is high.
- R11: A configuration write is applied at the clock edge that ends the write cycle. A fetch in the same cycle as the write is compared against the old values, and a fetch in the next cycle is compared against the new values. A write to word 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| priv_user | input | 1 | Current privilege: 1 = user, 0 = supervisor |
| addr_space | input | 1 | Current instruction address-space bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select: 0 = A, 1 = B, 2 = control |
| cfg_wdata | input | 32 | Configuration write data |
| evt_a | output | 1 | Event from comparator A, or the combined event |
| evt_b | output | 1 | Event from comparator B (exact mode only) |

## Verification
The assertions check the following on every cycle:
- both events stay low without fetch_valid;
- each event stays low while its enable is clear;
- event B stays low in the combined modes;
- event A stays low under the reserved privilege code or the real-address code;
- a control write lands in the register on the following edge.

The arithmetic of each mode only shows up in the bench's scenarios: exact equality, masked equality, and the window edges at A-1, A, B-1 and B. The bench also covers the same-cycle ordering of a write against a fetch, and the interaction of the qualifier codes with the live privilege and space bits. It checks these against its own reference model.

// File: rtl/iac_pkg.sv
package iac_pkg;

  typedef enum logic [1:0] {
    MODE_EXACT     = 2'b00,
    MODE_MASK      = 2'b01,
    MODE_WIN_IN    = 2'b10,
    MODE_WIN_OUT   = 2'b11
  } iac_mode_e;

  // Control word, LSB first: en_a, en_b, priv_a, space_a, priv_b, space_b, mode
  typedef struct packed {
    iac_mode_e  mode;     // [11:10]
    logic [1:0] space_b;  // [9:8]
    logic [1:0] priv_b;   // [7:6]
    logic [1:0] space_a;  // [5:4]
    logic [1:0] priv_a;   // [3:2]
    logic       en_b;     // [1]
    logic       en_a;     // [0]
  } iac_ctl_t;

  localparam int unsigned CTL_W = $bits(iac_ctl_t);

  localparam logic [1:0] WSEL_A   = 2'd0;
  localparam logic [1:0] WSEL_B   = 2'd1;
  localparam logic [1:0] WSEL_CTL = 2'd2;

endpackage

// File: rtl/iac_rst_sync.sv
module iac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iac_regs.sv
module iac_regs
  import iac_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    wsel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] ra_q,
  output logic [AW-1:0] rb_q,
  output iac_ctl_t      ctl_q
);
  logic [AW-1:0] ra_d, rb_d;
  iac_ctl_t      ctl_d;
  logic          ra_en, rb_en, ctl_en;

  always_comb begin
    ra_en  = we && (wsel == WSEL_A);
    rb_en  = we && (wsel == WSEL_B);
    ctl_en = we && (wsel == WSEL_CTL);
    ra_d   = ra_en  ? wdata : ra_q;
    rb_d   = rb_en  ? wdata : rb_q;
    ctl_d  = ctl_en ? iac_ctl_t'(wdata[CTL_W-1:0]) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q  <= '0;
      rb_q  <= '0;
      ctl_q <= '0;
    end else begin
      ra_q  <= ra_d;
      rb_q  <= rb_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/iac_qual.sv
module iac_qual (
  input  logic [1:0] priv_sel,
  input  logic [1:0] space_sel,
  input  logic       priv_user,
  input  logic       addr_space,
  output logic       pass
);
  logic priv_ok, space_ok;

  always_comb begin
    unique case (priv_sel)
      2'b00:   priv_ok = 1'b1;
      2'b10:   priv_ok = !priv_user;
      2'b11:   priv_ok = priv_user;
      default: priv_ok = 1'b0;        // reserved code
    endcase
    unique case (space_sel)
      2'b00:   space_ok = 1'b1;
      2'b10:   space_ok = !addr_space;
      2'b11:   space_ok = addr_space;
      default: space_ok = 1'b0;       // real-address compare absent
    endcase
    pass = priv_ok && space_ok;
  end
endmodule

// File: rtl/iac_match.sv
module iac_match
  import iac_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] fetch,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  iac_mode_e     mode,
  output logic          hit_a,
  output logic          hit_b
);
  logic eq_a, eq_b, mask_eq, ge_a, lt_b;

  always_comb begin
    eq_a    = (fetch == ra);
    eq_b    = (fetch == rb);
    mask_eq = ((fetch & rb) == (ra & rb));
    ge_a    = (fetch >= ra);
    lt_b    = (fetch <  rb);
    hit_b   = 1'b0;
    unique case (mode)
      MODE_EXACT:  begin hit_a = eq_a; hit_b = eq_b; end
      MODE_MASK:   hit_a = mask_eq;
      MODE_WIN_IN: hit_a = ge_a && lt_b;
      default:     hit_a = !ge_a || !lt_b;
    endcase
  end
endmodule

// File: rtl/iac_pair.sv
module iac_pair
  import iac_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          priv_user,
  input  logic          addr_space,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic          evt_a,
  output logic          evt_b
);
  localparam int unsigned NCMP = 2;

  logic          rst_sync_n;
  logic [AW-1:0] ra_q, rb_q;
  iac_ctl_t      ctl_q;
  logic          hit_a, hit_b;
  logic [NCMP-1:0] qpass;
  logic [NCMP-1:0] en_vec;
  logic [1:0]      priv_sel [NCMP];
  logic [1:0]      space_sel[NCMP];
  logic            combined;

  iac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  iac_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .wsel(cfg_addr),
    .wdata(cfg_wdata), .ra_q(ra_q), .rb_q(rb_q), .ctl_q(ctl_q)
  );

  always_comb begin
    priv_sel[0]  = ctl_q.priv_a;
    priv_sel[1]  = ctl_q.priv_b;
    space_sel[0] = ctl_q.space_a;
    space_sel[1] = ctl_q.space_b;
    en_vec       = {ctl_q.en_b, ctl_q.en_a};
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_qual
    iac_qual u_qual (
      .priv_sel(priv_sel[i]), .space_sel(space_sel[i]),
      .priv_user(priv_user), .addr_space(addr_space), .pass(qpass[i])
    );
  end

  iac_match #(.AW(AW)) u_match (
    .fetch(fetch_addr), .ra(ra_q), .rb(rb_q), .mode(ctl_q.mode),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  always_comb begin
    combined = (ctl_q.mode != MODE_EXACT);
    evt_a = fetch_valid && en_vec[0] && qpass[0] && hit_a;
    evt_b = fetch_valid && en_vec[1] && qpass[1] && hit_b && !combined;
  end
endmodule

// File: rtl/iac_pair_chk.sv
module iac_pair_chk
  import iac_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic          evt_a,
  input logic          evt_b,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [AW-1:0] cfg_wdata,
  input iac_ctl_t      ctl
);
  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a || evt_b) |-> fetch_valid);

  p_en_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en_a |-> !evt_a);

  p_en_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en_b |-> !evt_b);

  p_b_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode != MODE_EXACT) |-> !evt_b);

  p_priv_rsv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.priv_a == 2'b01) |-> !evt_a);

  p_space_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.space_a == 2'b01) |-> !evt_a);

  p_ctl_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == WSEL_CTL) |=> (ctl == $past(cfg_wdata[CTL_W-1:0])));
endmodule

bind iac_pair iac_pair_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fetch_valid(fetch_valid),
  .evt_a(evt_a), .evt_b(evt_b), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .ctl(ctl_q)
);

// File: tb/iac_pair_bench.sv
module iac_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid, priv_user, addr_space, cfg_we;
  logic [31:0] fetch_addr, cfg_wdata;
  logic [1:0]  cfg_addr;
  logic        evt_a, evt_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] sh_a, sh_b;
  logic [11:0] sh_ctl;

  always #5 clk = ~clk;

  iac_pair u_iac_pair (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .priv_user(priv_user), .addr_space(addr_space), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .evt_a(evt_a), .evt_b(evt_b)
  );

  function automatic logic qual_ok(input logic [1:0] pc, input logic [1:0] sc,
                                   input logic pr, input logic sp);
    logic p, s;
    p = (pc == 2'b00) || (pc == 2'b10 && !pr) || (pc == 2'b11 && pr);
    s = (sc == 2'b00) || (sc == 2'b10 && !sp) || (sc == 2'b11 && sp);
    return p && s;
  endfunction

  // returns {evt_b, evt_a}
  function automatic logic [1:0] model(input logic v, input logic [31:0] f,
                                       input logic pr, input logic sp);
    logic ha, hb;
    hb = 1'b0;
    case (sh_ctl[11:10])
      2'b00: begin ha = (f == sh_a); hb = (f == sh_b); end
      2'b01: ha = ((f & sh_b) == (sh_a & sh_b));
      2'b10: ha = (f >= sh_a) && (f < sh_b);
      default: ha = (f < sh_a) || (f >= sh_b);
    endcase
    return {v && sh_ctl[1] && qual_ok(sh_ctl[7:6], sh_ctl[9:8], pr, sp) && hb,
            v && sh_ctl[0] && qual_ok(sh_ctl[3:2], sh_ctl[5:4], pr, sp) && ha};
  endfunction

  function automatic logic [11:0] ctlw(input logic [1:0] md, input logic [1:0] sb,
      input logic [1:0] pb, input logic [1:0] sa, input logic [1:0] pa,
      input logic eb, input logic ea);
    return {md, sb, pb, sa, pa, eb, ea};
  endfunction

  // One cycle: optional write, one fetch, check against exp (or model when use_model)
  task automatic cyc(input logic we, input logic [1:0] wa, input logic [31:0] wd,
                     input logic fv, input logic [31:0] fa, input logic pr,
                     input logic sp, input string tag, input logic use_model,
                     input logic [1:0] exp_in);
    logic [1:0] exp;
    @(negedge clk);
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    fetch_valid = fv; fetch_addr = fa; priv_user = pr; addr_space = sp;
    #2;
    if (tag != "") begin
      exp = use_model ? model(fv, fa, pr, sp) : exp_in;
      checks++;
      if ({evt_b, evt_a} !== exp) begin
        fails++;
        $display("FAIL %s: evt{b,a} actual=%b expected=%b addr=%h", tag, {evt_b, evt_a}, exp, fa);
      end
    end
    @(posedge clk);
    if (we) begin
      if (wa == 2'd0) sh_a = wd;
      else if (wa == 2'd1) sh_b = wd;
      else if (wa == 2'd2) sh_ctl = wd[11:0];
    end
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] wa, input logic [31:0] wd);
    cyc(1'b1, wa, wd, 1'b0, 32'h0, 1'b0, 1'b0, "", 1'b0, 2'b00);
  endtask

  task automatic fx(input logic [31:0] fa, input logic pr, input logic sp,
                    input string tag, input logic [1:0] exp);
    cyc(1'b0, 2'd0, 32'h0, 1'b1, fa, pr, sp, tag, 1'b0, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    sh_a = '0; sh_b = '0; sh_ctl = '0;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    fetch_valid = 0; fetch_addr = 0; priv_user = 0; addr_space = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset leaves everything disabled, registers zero
    fx(32'h0, 1'b0, 1'b0, "R1", 2'b00);
    wr(2'd2, 32'h3);
    fx(32'h0, 1'b0, 1'b0, "R1", 2'b11);     // A = B = 0 after reset

    // R3: exact compare, independent
    wr(2'd0, 32'h0000_1000); wr(2'd1, 32'h0000_2000);
    fx(32'h0000_1000, 0, 0, "R3", 2'b01);
    fx(32'h0000_2000, 0, 0, "R3", 2'b10);
    fx(32'h0000_1004, 0, 0, "R3", 2'b00);

    // R2: enables gate each event
    wr(2'd2, 32'h1);
    fx(32'h0000_2000, 0, 0, "R2", 2'b00);
    wr(2'd2, 32'h0);
    fx(32'h0000_1000, 0, 0, "R2", 2'b00);

    // R10: no fetch_valid, no event
    wr(2'd2, 32'h3);
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 32'h0000_1000, 0, 0, "R10", 1'b0, 2'b00);

    // R7: privilege codes on A
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 1'b0, 1'b1)});
    fx(32'h0000_1000, 0, 0, "R7", 2'b00);
    fx(32'h0000_1000, 1, 0, "R7", 2'b00);
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 1'b0, 1'b1)});
    fx(32'h0000_1000, 0, 0, "R7", 2'b01);
    fx(32'h0000_1000, 1, 0, "R7", 2'b00);
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 1'b1, 1'b1)});
    fx(32'h0000_1000, 1, 0, "R7", 2'b01);
    fx(32'h0000_2000, 0, 0, "R7", 2'b00);

    // R8: address-space codes on B
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0)});
    fx(32'h0000_2000, 0, 0, "R8", 2'b00);
    fx(32'h0000_2000, 0, 1, "R8", 2'b00);
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0)});
    fx(32'h0000_2000, 0, 1, "R8", 2'b10);
    fx(32'h0000_2000, 0, 0, "R8", 2'b00);
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 1'b0, 1'b1)});
    fx(32'h0000_1000, 0, 0, "R8", 2'b01);
    fx(32'h0000_1000, 0, 1, "R8", 2'b00);

    // R5: inclusive window edges, A=100 B=200
    wr(2'd0, 32'd100); wr(2'd1, 32'd200);
    wr(2'd2, {20'h0, ctlw(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1)});
    fx(32'd99,  0, 0, "R5", 2'b00);
    fx(32'd100, 0, 0, "R5", 2'b01);
    fx(32'd199, 0, 0, "R5", 2'b01);
    fx(32'd200, 0, 0, "R5", 2'b00);

    // R6: outside window edges
    wr(2'd2, {20'h0, ctlw(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1)});
    fx(32'd99,  0, 0, "R6", 2'b01);
    fx(32'd100, 0, 0, "R6", 2'b00);
    fx(32'd199, 0, 0, "R6", 2'b00);
    fx(32'd200, 0, 0, "R6", 2'b01);
    fx(32'hFFFF_FFFF, 0, 0, "R6", 2'b01);

    // R4: masked match, A=0x1234_5600 mask B=0xFFFF_FF00
    wr(2'd0, 32'h1234_5600); wr(2'd1, 32'hFFFF_FF00);
    wr(2'd2, {20'h0, ctlw(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1)});
    fx(32'h1234_56AB, 0, 0, "R4", 2'b01);
    fx(32'h1234_57AB, 0, 0, "R4", 2'b00);

    // R9: combined mode uses only A qualifiers, B never fires
    wr(2'd0, 32'd100); wr(2'd1, 32'd200);
    wr(2'd2, {20'h0, ctlw(2'b10, 2'b01, 2'b01, 2'b00, 2'b00, 1'b1, 1'b1)});
    fx(32'd150, 0, 0, "R9", 2'b01);
    fx(32'd200, 0, 0, "R9", 2'b00);
    wr(2'd2, {20'h0, ctlw(2'b10, 2'b00, 2'b00, 2'b00, 2'b11, 1'b1, 1'b0)});
    fx(32'd150, 1, 0, "R9", 2'b00);

    // R11: write and fetch in same cycle uses old value
    wr(2'd2, {20'h0, ctlw(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1)});
    cyc(1'b1, 2'd0, 32'h0000_0ABC, 1'b1, 32'h0000_0ABC, 0, 0, "R11", 1'b0, 2'b00);
    fx(32'h0000_0ABC, 0, 0, "R11", 2'b01);
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1, 32'h0000_0ABC, 0, 0, "R11", 1'b0, 2'b01);
    fx(32'h0000_0ABC, 0, 0, "R11", 2'b01);

    // Random configurations with fetches near the compare values
    for (int n = 0; n < 300; n++) begin
      logic [31:0] base;
      string tg;
      wr(2'd0, $urandom);
      wr(2'd1, ($urandom_range(0, 3) == 0) ? sh_a + $urandom_range(0, 64) : $urandom);
      wr(2'd2, $urandom & 32'hFFF | (($urandom_range(0, 1) != 0) ? 32'h3 : 32'h0));
      case (sh_ctl[11:10])
        2'b00: tg = "R3";
        2'b01: tg = "R4";
        2'b10: tg = "R5";
        default: tg = "R6";
      endcase
      for (int k = 0; k < 8; k++) begin
        case ($urandom_range(0, 3))
          0: base = sh_a;
          1: base = sh_b;
          2: base = sh_a + $urandom_range(0, 3) - 1;
          default: base = $urandom;
        endcase
        cyc(1'b0, 2'd0, 32'h0, $urandom_range(0, 7) != 0, base,
            $urandom_range(0, 1), $urandom_range(0, 1), tg, 1'b1, 2'b00);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule